// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a single-clock synchronous static memory whose command inputs (chip select, write enable, per-lane write enables and address) are all taken on the rising clock edge. A read drives data from an output register in the cycle after the command. A write presents its address in one cycle and its data one cycle later. This is the late-write convention, so a write's data crosses the data bus in the same slot where a read's data would appear.

The write data is held in a single pending-write register, together with its address and lane mask. It enters the array only when the next write command arrives. If that write command comes on the very edge where the data is still arriving, the data goes straight from the bus into the array. Reads use the array only on read edges and commits use it only on write edges, so the two never compete. A read whose address matches a write that has not yet reached the array gets the pending lanes merged over the array contents.

The word is four 9-bit lanes, and the depth is set by the address width. The bus is split into `wdata`, `rdata` and a drive qualifier `bus_drive`. `rdata` reads as zero whenever the drivers are off.

Top module: `lw_sram`

## Requirements
- R1: While reset is held and after it is released, `bus_drive` is 0 and `rdata` is 0 until the first read command.
- R2: A read command (`sel_n`=0, `wr_n`=1) sampled at edge N makes `rdata` carry the addressed word and `bus_drive` equal 1 from edge N until edge N+1, provided `out_en_n` is 0.
- R3: A write command sampled at edge N takes its data from `wdata` at edge N+1, and a later read of that address returns it.
- R4: Lane i covers bits [9i+8:9i]. On a write, lane i is written only when `lane_wr_n[i]` is 0, and a lane with `lane_wr_n[i]`=1 keeps its previous contents.
- R5: A read of an address whose write has not reached the array returns the enabled lanes of that write merged over the older contents. This includes a read issued on the edge where the write data is still on `wdata`.
- R6: Write commands on consecutive edges are all kept, and each address later reads back its own data.
- R7: With `sel_n`=1 no operation takes place, whatever `wr_n` and the lane enables are. After that edge `bus_drive` is 0 and `rdata` is 0.
- R8: A write command sampled at an edge turns the bus drivers off from that edge on.
- R9: `out_en_n`=1 forces `bus_drive` and `rdata` to 0 at once, without waiting for a clock edge. Returning it to 0 restores the registered read data.
- R10: At most one write is waiting for the array at any time. It is committed only on the next write-command edge, and a read never shares an edge with a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write command (read when high) |
| lane_wr_n | input | 4 | Active-low per-lane write enables |
| addr | input | AW | Word address |
| wdata | input | 36 | Write data, sampled one edge after its write command |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 36 | Registered read data, zero while not driving |
| bus_drive | output | 1 | High when the block drives the data bus |

## Verification
On every cycle the assertions check the output-driver rules: floating after a deselect or a write, and driving after a read when enabled. They also check the pending-write invariants, namely that a write arriving on the bus never finds another write still waiting, and that every write-command edge leaves the holding register empty. Whether the data is correct can only be shown by the bench scenarios, which compare reads against a reference model. These scenarios cover forwarding from the bus and from the holding register, partial-lane merges, writes on consecutive edges, and commits delayed across runs of reads.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  parameter int LANES  = 4;
  parameter int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;

  // Replace the lanes selected by take with the lanes of upd.
  function automatic word_t lane_merge(input word_t base, input word_t upd, input lane_t take);
    word_t r;
    r = base;
    for (int i = 0; i < LANES; i++) begin
      if (take[i]) r[i*LANE_W +: LANE_W] = upd[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import lw_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          wr_n,
  input  lane_t         lane_wr_n,
  input  logic [AW-1:0] addr,
  output logic          rd_cmd,
  output logic          wr_cmd,
  output logic          drive_q,
  output logic          infl_vld,
  output logic [AW-1:0] infl_addr,
  output lane_t         infl_mask
);
  assign rd_cmd = !sel_n && wr_n;
  assign wr_cmd = !sel_n && !wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_q   <= 1'b0;
      infl_vld  <= 1'b0;
      infl_addr <= '0;
      infl_mask <= '0;
    end else begin
      drive_q  <= rd_cmd;
      infl_vld <= wr_cmd;
      if (wr_cmd) begin
        infl_addr <= addr;
        infl_mask <= ~lane_wr_n;
      end
    end
  end

  AST_WRITE_HAS_DATA_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> infl_vld); // R3
endmodule

// File: rtl/lw_wbuf.sv
module lw_wbuf
  import lw_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          infl_vld,
  input  logic [AW-1:0] infl_addr,
  input  lane_t         infl_mask,
  input  word_t         bus_in,
  input  logic          wr_slot,
  output logic          commit_en,
  output logic [AW-1:0] cm_addr,
  output word_t         cm_data,
  output lane_t         cm_mask,
  output logic          hold_vld,
  output logic [AW-1:0] hold_addr,
  output word_t         hold_data,
  output lane_t         hold_mask
);
  logic direct_cm;
  logic held_cm;

  // A write slot commits the data arriving on the bus now, or else the held write.
  assign direct_cm = wr_slot && infl_vld;
  assign held_cm   = wr_slot && !infl_vld && hold_vld;
  assign commit_en = direct_cm || held_cm;
  assign cm_addr   = direct_cm ? infl_addr : hold_addr;
  assign cm_data   = direct_cm ? bus_in    : hold_data;
  assign cm_mask   = direct_cm ? infl_mask : hold_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      hold_mask <= '0;
    end else if (held_cm) begin
      hold_vld <= 1'b0;
    end else if (infl_vld && !wr_slot) begin
      hold_vld  <= 1'b1;
      hold_addr <= infl_addr;
      hold_data <= bus_in;
      hold_mask <= infl_mask;
    end
  end

  AST_SINGLE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    infl_vld |-> !hold_vld); // R10
  AST_SLOT_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_slot |=> !hold_vld); // R6
endmodule

// File: rtl/lw_array.sv
module lw_array
  import lw_sram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  word_t         wr_data,
  input  lane_t         wr_mask,
  input  logic [AW-1:0] rd_addr,
  output word_t         rd_data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_mask[g]) cells[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end
    assign rd_data[g*LANE_W +: LANE_W] = cells[rd_addr];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic [3:0]    lane_wr_n,
  input  logic [AW-1:0] addr,
  input  logic [35:0]   wdata,
  input  logic          out_en_n,
  output logic [35:0]   rdata,
  output logic          bus_drive
);
  localparam int DEPTH = 1 << AW;

  logic          rd_cmd, wr_cmd, drive_q;
  logic          infl_vld;
  logic [AW-1:0] infl_addr;
  lane_t         infl_mask;
  logic          commit_en;
  logic [AW-1:0] cm_addr;
  word_t         cm_data;
  lane_t         cm_mask;
  logic          hold_vld;
  logic [AW-1:0] hold_addr;
  word_t         hold_data;
  lane_t         hold_mask;
  word_t         arr_word, after_hold, read_word, out_q;
  logic          hit_hold, hit_infl;

  lw_cmd_stage #(.AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .addr(addr),
    .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .drive_q(drive_q),
    .infl_vld(infl_vld), .infl_addr(infl_addr), .infl_mask(infl_mask)
  );

  lw_wbuf #(.AW(AW)) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .infl_vld(infl_vld), .infl_addr(infl_addr), .infl_mask(infl_mask),
    .bus_in(wdata), .wr_slot(wr_cmd),
    .commit_en(commit_en), .cm_addr(cm_addr), .cm_data(cm_data), .cm_mask(cm_mask),
    .hold_vld(hold_vld), .hold_addr(hold_addr), .hold_data(hold_data), .hold_mask(hold_mask)
  );

  lw_array #(.AW(AW), .DEPTH(DEPTH)) u_array (
    .clk(clk), .wr_en(commit_en), .wr_addr(cm_addr), .wr_data(cm_data),
    .wr_mask(cm_mask), .rd_addr(addr), .rd_data(arr_word)
  );

  // Forwarding: held write over the array, then the write arriving on the bus.
  assign hit_hold   = hold_vld && (hold_addr == addr);
  assign hit_infl   = infl_vld && (infl_addr == addr);
  assign after_hold = lane_merge(arr_word, hold_data, hit_hold ? hold_mask : '0);
  assign read_word  = lane_merge(after_hold, wdata, hit_infl ? infl_mask : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else if (rd_cmd) out_q <= read_word;
  end

  assign bus_drive = drive_q && !out_en_n;
  assign rdata     = bus_drive ? out_q : '0;

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> (out_en_n || bus_drive)); // R2
  AST_DESEL_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !bus_drive); // R7
  AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !wr_n) |=> !bus_drive); // R8
  AST_NO_READ_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_en && rd_cmd)); // R10
endmodule

// File: tb/lw_sram_bench.sv
`timescale 1ns/100ps
module lw_sram_bench;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [3:0]    lane_wr_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [35:0]   wdata = '0;
  logic          out_en_n = 1'b0;
  logic [35:0]   rdata;
  logic          bus_drive;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [35:0] carry;
  logic [35:0] model [int];

  localparam logic [35:0] JUNK = 36'h9BADBAD00;

  always #2.5 clk = ~clk;

  lw_sram #(.AW(AW)) u_lw_sram (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .wdata(wdata), .out_en_n(out_en_n), .rdata(rdata), .bus_drive(bus_drive)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, return 1 ns after the rising edge.
  task automatic step(input logic s, input logic w, input logic [3:0] be, input logic [AW-1:0] a);
    @(negedge clk);
    sel_n = s; wr_n = w; lane_wr_n = be; addr = a; wdata = carry;
    carry = JUNK;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [35:0] d);
    logic [35:0] nv;
    nv = model.exists(int'(a)) ? model[int'(a)] : 36'h0;
    for (int b = 0; b < 36; b++) if (!be[b/9]) nv[b] = d[b];
    step(1'b0, 1'b0, be, a);
    carry = d;
    model[int'(a)] = nv;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    step(1'b0, 1'b1, 4'hF, a);
    chk(req, rdata, model[int'(a)]);
    chk(req, {35'd0, bus_drive}, 36'd1);
  endtask

  task automatic idle();
    step(1'b1, 1'b1, 4'hF, '0);
  endtask

  task automatic t_reset();
    chk("R1 reset drive", {35'd0, bus_drive}, 36'd0);
    chk("R1 reset data", rdata, 36'd0);
  endtask

  task automatic t_basic();
    wr(8'h10, 4'h0, 36'h123456789);
    idle(); idle();
    rd(8'h10, "R3 late write readback");
    rd(8'h10, "R2 read drives next cycle");
  endtask

  task automatic t_fwd();
    wr(8'h20, 4'h0, 36'hABCDEF012);
    rd(8'h20, "R5 forward from bus");
    rd(8'h20, "R5 forward from holding register");
  endtask

  task automatic t_partial();
    wr(8'h30, 4'h0, 36'h111111111);
    idle();
    wr(8'h30, 4'b1010, 36'hFFFFFFFFF);   // lanes 0 and 2
    rd(8'h30, "R4 partial forward from bus");
    rd(8'h30, "R4 partial from holding register");
    wr(8'h31, 4'b0111, 36'h5AAAAAAAA);   // lane 3 only, commits 0x30
    wr(8'h31, 4'b1000, 36'h02468ACE1);   // lanes 0..2
    idle();
    rd(8'h30, "R4 partial after commit");
    rd(8'h31, "R4 two partial writes merge");
  endtask

  task automatic t_b2b();
    for (int i = 0; i < 4; i++) wr(AW'(8'h40 + i), 4'h0, 36'h100000000 * (i + 1) + 36'h7);
    idle();
    for (int i = 3; i >= 0; i--) rd(AW'(8'h40 + i), "R6 back-to-back writes");
  endtask

  task automatic t_defer();
    wr(8'h50, 4'h0, 36'h0DEF0DEF0);
    for (int i = 0; i < 3; i++) rd(AW'(8'h40 + i), "R10 reads while write pending");
    rd(8'h50, "R10 pending visible");
    wr(8'h51, 4'h0, 36'h876543210);
    rd(8'h50, "R10 committed at next write");
    rd(8'h51, "R10 newest write forwarded");
  endtask

  task automatic t_desel();
    rd(8'h10, "R7 setup read");
    step(1'b1, 1'b0, 4'h0, 8'h10);
    chk("R7 deselect floats", {35'd0, bus_drive}, 36'd0);
    chk("R7 deselect data zero", rdata, 36'd0);
    idle();
    wr(8'h60, 4'h0, 36'h333333333);
    wr(8'h61, 4'h0, 36'h444444444);
    idle();
    rd(8'h10, "R7 deselected write ignored");
  endtask

  task automatic t_wfloat();
    rd(8'h20, "R8 setup read");
    wr(8'h62, 4'h0, 36'h777000777);
    chk("R8 write floats bus", {35'd0, bus_drive}, 36'd0);
    rd(8'h62, "R8 data after floating");
  endtask

  task automatic t_oe();
    rd(8'h41, "R9 setup read");
    out_en_n = 1'b1;
    #0.5;
    chk("R9 async float", {35'd0, bus_drive}, 36'd0);
    chk("R9 async data zero", rdata, 36'd0);
    out_en_n = 1'b0;
    #0.5;
    chk("R9 restore drive", rdata, model[8'h41]);
  endtask

  initial begin
    carry = JUNK;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_basic();
    t_fwd();
    t_partial();
    t_b2b();
    t_defer();
    t_desel();
    t_wfloat();
    t_oe();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule